// File: doc/BRIEF.md
# Per-Warp Memory Fence Scoreboard

This block sits beside the issue stage of a GPU core and decides, every cycle, whether the instruction a warp is about to issue may go now under the current memory-ordering mode. For each warp it keeps two counters: global loads still in flight and global stores still in flight. A counter goes up when the matching global access is granted. It goes down when the memory system returns a completion that names that warp and that access type. Accesses to on-chip shared scratchpad memory are never counted.

Instructions within a warp issue in program order, and only their completion can be out of order. Because of this, holding a warp until both of its counters are zero is enough to enforce a fence. In relaxed (data-race-free) mode, only explicit fences and synchronization operations wait for the counters to drain. In sequentially consistent mode, every shared or global access also waits as though it were a fence. Stalls are tracked per warp, so a warp that is held never blocks the others.

Top module: `fence_scoreboard`

## Requirements
- R1: A granted global load (op code 1) or global store (op code 2) adds one to that warp's load or store counter, and the new value is visible on the observation port one cycle after the grant.
- R2: Shared loads (op code 3) and shared stores (op code 4) never change either counter.
- R3: A fence (op code 5) or synchronization operation (op code 6) is granted only while both counters of its warp are zero. `fence_clear[w]` is high exactly when both counters of warp w are zero.
- R4: With `mode_sc`=0, non-memory operations (op codes 0 and 7), shared accesses and global accesses are granted whatever the pending counts are, unless R8 applies.
- R5: With `mode_sc`=1, a shared or global access is granted only while both counters of its warp are zero. Non-memory operations are still granted.
- R6: A completion (`cpl_is_store` 0 for a load, 1 for a store) subtracts one from the named warp's matching counter. A grant and a completion on the same warp and the same counter in one cycle leave that counter unchanged.
- R7: A completion naming a counter that is already zero raises `underflow_err` in that same cycle, and the counter stays at zero.
- R8: A global access whose counter is at its maximum value (2^CNT_W-1) is not granted, and the counter keeps that value.
- R9: Counters, stalls and fence readiness are separate for each warp. A stalled warp does not affect grants to any other warp.
- R10: Reset clears every counter, so every bit of `fence_clear` is high.
- R11: A warp id of NUM_WARPS or above is never granted. Completions that name such an id are ignored, and the observation port reads zero for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sc | input | 1 | 1 selects sequentially consistent ordering, 0 selects relaxed ordering |
| iss_valid | input | 1 | An issue request is present |
| iss_warp | input | WID_W | Warp id of the request |
| iss_op | input | 3 | Operation class: 0 none, 1 global load, 2 global store, 3 shared load, 4 shared store, 5 fence, 6 sync, 7 none |
| iss_grant | output | 1 | The request may issue in this cycle |
| cpl_valid | input | 1 | A completion is returned |
| cpl_warp | input | WID_W | Warp id of the completion |
| cpl_is_store | input | 1 | 1 for a store completion, 0 for a load completion |
| underflow_err | output | 1 | The completion names a counter that is already zero |
| fence_clear | output | NUM_WARPS | Per-warp flag: no global access is pending |
| obs_warp | input | WID_W | Warp selected for the count outputs |
| obs_loads | output | CNT_W | Pending global loads of obs_warp |
| obs_stores | output | CNT_W | Pending global stores of obs_warp |

## Verification
The assertions check several rules on every cycle. No fence or sync grant, and no grant of a memory access in sequentially consistent mode, happens while the warp has anything pending. A granted global access always leaves its warp not clear on the next cycle. A granted shared access with no completion in flight leaves readiness unchanged. A completion on an empty warp always raises the error. The bench scenarios cover what the assertions cannot see: exact counter values after simultaneous issue and completion, saturation at the counter limit, independence between warps, out-of-range ids, and the state after a reset in the middle of traffic.

// File: rtl/fence_scoreboard.sv
module fence_scoreboard #(
  parameter int NUM_WARPS = 48,
  parameter int CNT_W     = 6,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_sc,
  input  logic                 iss_valid,
  input  logic [WID_W-1:0]     iss_warp,
  input  logic [2:0]           iss_op,
  output logic                 iss_grant,
  input  logic                 cpl_valid,
  input  logic [WID_W-1:0]     cpl_warp,
  input  logic                 cpl_is_store,
  output logic                 underflow_err,
  output logic [NUM_WARPS-1:0] fence_clear,
  input  logic [WID_W-1:0]     obs_warp,
  output logic [CNT_W-1:0]     obs_loads,
  output logic [CNT_W-1:0]     obs_stores
);
  localparam logic [2:0] OP_GLD = 3'd1, OP_GST = 3'd2, OP_SLD = 3'd3,
                         OP_SST = 3'd4, OP_FEN = 3'd5, OP_SYN = 3'd6;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ld_q [NUM_WARPS];
  logic [CNT_W-1:0] st_q [NUM_WARPS];

  logic iss_in, cpl_in, obs_in;
  assign iss_in = 32'(iss_warp) < NUM_WARPS;
  assign cpl_in = 32'(cpl_warp) < NUM_WARPS;
  assign obs_in = 32'(obs_warp) < NUM_WARPS;

  logic is_gld, is_gst, is_shr, is_fen;
  assign is_gld = iss_op == OP_GLD;
  assign is_gst = iss_op == OP_GST;
  assign is_shr = (iss_op == OP_SLD) || (iss_op == OP_SST);
  assign is_fen = (iss_op == OP_FEN) || (iss_op == OP_SYN);

  logic [CNT_W-1:0] cur_ld, cur_st, cpl_ld, cpl_st;
  assign cur_ld = iss_in ? ld_q[iss_warp] : '0;
  assign cur_st = iss_in ? st_q[iss_warp] : '0;
  assign cpl_ld = cpl_in ? ld_q[cpl_warp] : '0;
  assign cpl_st = cpl_in ? st_q[cpl_warp] : '0;

  logic drain, quiet, sat;
  assign drain = is_fen || (mode_sc && (is_gld || is_gst || is_shr));
  assign quiet = (cur_ld == '0) && (cur_st == '0);
  assign sat   = (is_gld && cur_ld == CNT_MAX) || (is_gst && cur_st == CNT_MAX);

  assign iss_grant = iss_valid && iss_in && (!drain || quiet) && !sat;

  assign underflow_err = cpl_valid && cpl_in &&
                         (cpl_is_store ? (cpl_st == '0) : (cpl_ld == '0));

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic hit_i, hit_c, ld_inc, ld_dec, st_inc, st_dec;
    assign hit_i  = iss_grant && (iss_warp == WID_W'(g));
    assign hit_c  = cpl_valid && (cpl_warp == WID_W'(g));
    assign ld_inc = hit_i && is_gld;
    assign st_inc = hit_i && is_gst;
    assign ld_dec = hit_c && !cpl_is_store && (ld_q[g] != '0);
    assign st_dec = hit_c &&  cpl_is_store && (st_q[g] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ld_q[g] <= '0;
        st_q[g] <= '0;
      end else begin
        if (ld_inc && !ld_dec) ld_q[g] <= ld_q[g] + 1'b1;
        else if (ld_dec && !ld_inc) ld_q[g] <= ld_q[g] - 1'b1;
        if (st_inc && !st_dec) st_q[g] <= st_q[g] + 1'b1;
        else if (st_dec && !st_inc) st_q[g] <= st_q[g] - 1'b1;
      end
    end

    assign fence_clear[g] = (ld_q[g] == '0) && (st_q[g] == '0);
  end

  assign obs_loads  = obs_in ? ld_q[obs_warp] : '0;
  assign obs_stores = obs_in ? st_q[obs_warp] : '0;
endmodule

// File: rtl/fence_scoreboard_chk.sv
module fence_scoreboard_chk #(
  parameter int NUM_WARPS = 48,
  parameter int CNT_W     = 6,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_sc,
  input logic                 iss_valid,
  input logic [WID_W-1:0]     iss_warp,
  input logic [2:0]           iss_op,
  input logic                 iss_grant,
  input logic                 cpl_valid,
  input logic [WID_W-1:0]     cpl_warp,
  input logic                 underflow_err,
  input logic [NUM_WARPS-1:0] fence_clear
);
  logic iss_in, cpl_in, mem_op, fen_op;
  assign iss_in = 32'(iss_warp) < NUM_WARPS;
  assign cpl_in = 32'(cpl_warp) < NUM_WARPS;
  assign mem_op = (iss_op >= 3'd1) && (iss_op <= 3'd4);
  assign fen_op = (iss_op == 3'd5) || (iss_op == 3'd6);

  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> iss_valid && iss_in);                                      // R11
  AST_FENCE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && iss_in && fen_op) |-> fence_clear[iss_warp]);              // R3
  AST_SC_ACCESS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && iss_in && mode_sc && mem_op) |-> fence_clear[iss_warp]);   // R5
  AST_GLOBAL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && iss_in && (iss_op == 3'd1 || iss_op == 3'd2))
      |=> !fence_clear[$past(iss_warp)]);                                    // R1
  AST_SHARED_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && iss_in && (iss_op == 3'd3 || iss_op == 3'd4) && !cpl_valid)
      |=> fence_clear[$past(iss_warp)] == $past(fence_clear[iss_warp]));     // R2
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_in && fence_clear[cpl_warp]) |-> underflow_err);       // R7
  AST_RELAXED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_in && !mode_sc && !fen_op &&
     !(iss_op == 3'd1 || iss_op == 3'd2)) |-> iss_grant);                    // R4
endmodule

bind fence_scoreboard fence_scoreboard_chk #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sc(mode_sc), .iss_valid(iss_valid),
  .iss_warp(iss_warp), .iss_op(iss_op), .iss_grant(iss_grant),
  .cpl_valid(cpl_valid), .cpl_warp(cpl_warp), .underflow_err(underflow_err),
  .fence_clear(fence_clear)
);

// File: tb/fence_scoreboard_bench.sv
module fence_scoreboard_bench;
  localparam int NW = 48;
  localparam int CW = 6;
  localparam int WW = 6;

  logic clk = 0, rst_n = 0, mode_sc = 0, iss_valid = 0, cpl_valid = 0, cpl_is_store = 0;
  logic [WW-1:0] iss_warp = '0, cpl_warp = '0, obs_warp = '0;
  logic [2:0] iss_op = '0;
  logic iss_grant, underflow_err;
  logic [NW-1:0] fence_clear;
  logic [CW-1:0] obs_loads, obs_stores;

  always #5 clk = ~clk;

  fence_scoreboard u_fence_scoreboard (
    .clk(clk), .rst_n(rst_n), .mode_sc(mode_sc), .iss_valid(iss_valid),
    .iss_warp(iss_warp), .iss_op(iss_op), .iss_grant(iss_grant),
    .cpl_valid(cpl_valid), .cpl_warp(cpl_warp), .cpl_is_store(cpl_is_store),
    .underflow_err(underflow_err), .fence_clear(fence_clear),
    .obs_warp(obs_warp), .obs_loads(obs_loads), .obs_stores(obs_stores));

  typedef struct packed {
    logic sc; logic v; logic [5:0] w; logic [2:0] op;
    logic cv; logic [5:0] cw; logic cs;
    logic g; logic e; logic [5:0] ld; logic [5:0] st;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t TBL [NROWS] = '{
    '{1'b0,1'b1,6'd2, 3'd1,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd1,6'd0}, // R1 load
    '{1'b0,1'b1,6'd2, 3'd2,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd1,6'd1}, // R1 store
    '{1'b0,1'b1,6'd2, 3'd3,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd1,6'd1}, // R2 R4
    '{1'b0,1'b1,6'd2, 3'd1,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd2,6'd1}, // R4
    '{1'b0,1'b1,6'd2, 3'd5,1'b0,6'd0,1'b0, 1'b0,1'b0,6'd2,6'd1}, // R3 fence held
    '{1'b0,1'b1,6'd2, 3'd0,1'b1,6'd2,1'b0, 1'b1,1'b0,6'd1,6'd1}, // R6 decrement
    '{1'b0,1'b1,6'd2, 3'd1,1'b1,6'd2,1'b0, 1'b1,1'b0,6'd1,6'd1}, // R6 same cycle
    '{1'b1,1'b1,6'd2, 3'd4,1'b0,6'd0,1'b0, 1'b0,1'b0,6'd1,6'd1}, // R5 held
    '{1'b1,1'b1,6'd5, 3'd1,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd1,6'd0}, // R9 other warp
    '{1'b1,1'b1,6'd2, 3'd0,1'b1,6'd2,1'b0, 1'b1,1'b0,6'd0,6'd1}, // R5 alu
    '{1'b1,1'b1,6'd2, 3'd3,1'b1,6'd2,1'b1, 1'b0,1'b0,6'd0,6'd0}, // R5 store pending
    '{1'b1,1'b1,6'd2, 3'd3,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd0,6'd0}, // R5 R2
    '{1'b1,1'b1,6'd2, 3'd6,1'b0,6'd0,1'b0, 1'b1,1'b0,6'd0,6'd0}, // R3 sync
    '{1'b1,1'b0,6'd2, 3'd0,1'b1,6'd2,1'b1, 1'b0,1'b1,6'd0,6'd0}, // R7
    '{1'b1,1'b1,6'd50,3'd1,1'b1,6'd50,1'b0,1'b0,1'b0,6'd0,6'd0}, // R11
    '{1'b0,1'b0,6'd5, 3'd0,1'b1,6'd5,1'b0, 1'b0,1'b0,6'd0,6'd0}  // R6 warp5 drained
  };

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check(fence_clear == {NW{1'b1}}, "R10 fence_clear after reset", int'(fence_clear[31:0]), -1);
    check(obs_loads == 0 && obs_stores == 0, "R10 counts after reset", obs_loads + obs_stores, 0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      mode_sc = TBL[i].sc; iss_valid = TBL[i].v; iss_warp = TBL[i].w; iss_op = TBL[i].op;
      cpl_valid = TBL[i].cv; cpl_warp = TBL[i].cw; cpl_is_store = TBL[i].cs;
      obs_warp = TBL[i].v ? TBL[i].w : TBL[i].cw;
      #1;
      check(iss_grant == TBL[i].g, $sformatf("row %0d grant", i), iss_grant, TBL[i].g);
      check(underflow_err == TBL[i].e, $sformatf("row %0d R7 err", i), underflow_err, TBL[i].e);
      @(posedge clk); #1;
      check(obs_loads == TBL[i].ld, $sformatf("row %0d R1/R6 loads", i), obs_loads, TBL[i].ld);
      check(obs_stores == TBL[i].st, $sformatf("row %0d R1/R6 stores", i), obs_stores, TBL[i].st);
    end

    // R8 saturation on warp 7
    @(negedge clk);
    iss_valid = 0; cpl_valid = 0; mode_sc = 0;
    iss_warp = 7; iss_op = 3'd1; obs_warp = 7;
    for (int k = 0; k < 63; k++) begin
      @(negedge clk); iss_valid = 1; #1;
      check(iss_grant, "R8 below limit grant", iss_grant, 1);
    end
    @(negedge clk); #1;
    check(!iss_grant, "R8 saturated load held", iss_grant, 0);
    check(obs_loads == 63, "R8 count at max", obs_loads, 63);
    @(posedge clk); #1;
    check(obs_loads == 63, "R8 count kept", obs_loads, 63);

    // R9 other warps unaffected
    @(negedge clk); iss_warp = 8; iss_op = 3'd5; #1;
    check(iss_grant, "R9 other warp fence", iss_grant, 1);
    check(!fence_clear[7] && fence_clear[6], "R9 per-warp clear", fence_clear[7], 0);
    check(!fence_clear[7] && fence_clear[8], "R3 fence_clear follows counts", fence_clear[8], 1);

    // R7 underflow on store counter of warp 7 while loads pending
    @(negedge clk); iss_valid = 0; cpl_valid = 1; cpl_warp = 7; cpl_is_store = 1; #1;
    check(underflow_err, "R7 store underflow", underflow_err, 1);
    @(posedge clk); #1;
    check(obs_stores == 0 && obs_loads == 63, "R7 counters held", obs_stores, 0);

    // R10 reset mid-traffic
    @(negedge clk); cpl_valid = 0; rst_n = 0;
    @(posedge clk); #1;
    check(obs_loads == 0, "R10 reset clears", obs_loads, 0);
    check(fence_clear == {NW{1'b1}}, "R10 all clear", fence_clear[7], 1);
    @(negedge clk); rst_n = 1;
    finish_run();
  end
endmodule